// File: doc/BRIEF.md
# Password Retry Lockout Controller

This block decides whether a password attempt opens a small protected memory array, and defends that array against guessing. Another part of the chip first collects a command, an address and an 8-byte password. It then presents a single request word to this block: an operation code, a password kind and the 64-bit attempt. The block compares the attempt against three stored passwords: read, write and reset. It answers one cycle later with a grant or a deny.

Every wrong attempt advances a failure counter, whatever the kind of password was tried. A correct attempt before the limit brings the counter back to zero. One failure past the tolerated number locks the block and sends a one-cycle request to erase the array. While locked, every attempt on the array passwords is refused, but the stored passwords are kept. Only a reset-device request that carries the correct reset password unlocks the block. A separate reset-password request, also guarded by the reset password, erases the array and sets all three stored passwords to zero.

Top module: `pwl_lockout_top`

## Requirements
- R1: After reset, `locked_o`, `rsp_valid_o`, `rsp_grant_o` and `clr_array_o` are 0, and the stored read, write and reset passwords equal the parameters `INIT_READ_PW`, `INIT_WRITE_PW` and `INIT_RESET_PW`.
- R2: Every request (`req_valid_i`=1) produces `rsp_valid_o`=1 on the following cycle. A verify request (op 0) with kind 0 (read), 1 (write) or 2 (reset) is granted, while unlocked, exactly when `req_pw_i` equals the stored password of that kind. Kind 3 never matches.
- R3: A granted verify resets the failure count to zero, so the next run of failures starts again from the full allowance.
- R4: Up to `MAX_TRIES` (8) consecutive failures leave the block unlocked. The next failure sets `locked_o` and pulses `clr_array_o` for exactly one cycle, in the same cycle as that response.
- R5: The failure count advances on any denied request of op 0, 1 or 2 while unlocked, in any mix of kinds and ops.
- R6: While locked, a verify is denied even with the correct password, and it does not change the lock state.
- R7: Lockout leaves the stored passwords untouched. After unlocking, the original read and write passwords are granted again.
- R8: Reset-device (op 1) with the correct reset password, while unlocked, is granted, zeroes the failure count, gives no `clr_array_o` pulse and keeps the passwords.
- R9: Reset-device with the correct reset password while locked is granted and clears `locked_o`. No other request clears it.
- R10: Reset-password (op 2) with the correct reset password is granted, pulses `clr_array_o` for one cycle and sets all three stored passwords to zero.
- R11: Op 3 is reserved. It is denied and does not advance the failure count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_op_i | input | 2 | 0 verify, 1 reset-device, 2 reset-password, 3 reserved |
| req_kind_i | input | 2 | Password kind for verify: 0 read, 1 write, 2 reset |
| req_pw_i | input | 64 | Attempted password |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_grant_o | output | 1 | 1 grant, 0 deny; meaningful with rsp_valid_o |
| locked_o | output | 1 | Lockout flag |
| clr_array_o | output | 1 | One-cycle request to erase the memory array |

## Verification
Each result is registered once. The response, the clear pulse and the lock flag for a request sampled at one clock edge are all visible after that same edge. The bench drives each request on a falling edge and samples all four outputs on the next falling edge. Password changes from reset-password take effect from the next request, so they are observed through the grant of a later verify. Counter state is inferred only through when the lock flag rises.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  typedef enum logic [1:0] {
    OP_VERIFY = 2'd0,
    OP_RSTDEV = 2'd1,
    OP_RSTPW  = 2'd2,
    OP_RSVD   = 2'd3
  } pwl_op_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_RESET = 2'd2,
    KIND_NONE  = 2'd3
  } pwl_kind_e;

  localparam int NUM_SLOTS = 3;
endpackage

// File: rtl/pwl_pw_store.sv
module pwl_pw_store #(
  parameter int PW_BITS = 64,
  parameter int NUM_SLOTS = 3,
  parameter logic [NUM_SLOTS*PW_BITS-1:0] INIT_PW = '0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           zero_en_i,
  output logic [NUM_SLOTS*PW_BITS-1:0]   pw_flat_o
);
  logic [PW_BITS-1:0] pw_q [NUM_SLOTS];
  logic [PW_BITS-1:0] pw_d [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_comb begin
      pw_d[s] = pw_q[s];
      if (zero_en_i) pw_d[s] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pw_q[s] <= INIT_PW[s*PW_BITS +: PW_BITS];
      else if (zero_en_i) pw_q[s] <= pw_d[s];
    end

    assign pw_flat_o[s*PW_BITS +: PW_BITS] = pw_q[s];

    AST_ZERO_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      zero_en_i |=> (pw_q[s] == '0)); // R10
    AST_PW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !zero_en_i |=> $stable(pw_q[s])); // R7
  end
endmodule

// File: rtl/pwl_compare.sv
module pwl_compare
  import pwl_pkg::*;
#(
  parameter int PW_BITS = 64
) (
  input  logic [PW_BITS-1:0]           attempt_i,
  input  logic [NUM_SLOTS*PW_BITS-1:0] pw_flat_i,
  input  pwl_kind_e                    kind_i,
  output logic                         kind_hit_o,
  output logic                         reset_hit_o
);
  logic [NUM_SLOTS-1:0] slot_hit;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    assign slot_hit[s] = (attempt_i == pw_flat_i[s*PW_BITS +: PW_BITS]);
  end

  always_comb begin
    kind_hit_o = 1'b0;
    case (kind_i)
      KIND_READ:  kind_hit_o = slot_hit[0];
      KIND_WRITE: kind_hit_o = slot_hit[1];
      KIND_RESET: kind_hit_o = slot_hit[2];
      default:    kind_hit_o = 1'b0;
    endcase
  end

  assign reset_hit_o = slot_hit[2];
endmodule

// File: rtl/pwl_retry_cnt.sv
module pwl_retry_cnt #(
  parameter int MAX_TRIES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_i,
  input  logic clear_i,
  input  logic unlock_i,
  output logic locked_o,
  output logic overflow_o
);
  localparam int CW = $clog2(MAX_TRIES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_TRIES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lock_q, lock_d;
  logic          en;

  always_comb begin
    cnt_d      = cnt_q;
    lock_d     = lock_q;
    overflow_o = 1'b0;
    if (unlock_i) begin
      cnt_d  = '0;
      lock_d = 1'b0;
    end else if (!lock_q) begin
      if (clear_i) begin
        cnt_d = '0;
      end else if (fail_i) begin
        if (cnt_q == CNT_MAX) begin
          lock_d     = 1'b1;
          overflow_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  assign en = unlock_i | clear_i | fail_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign locked_o = lock_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R4
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !unlock_i) |=> ($stable(cnt_q) && lock_q)); // R6
  AST_NO_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fail_i && !clear_i && !unlock_i) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/pwl_lockout_top.sv
module pwl_lockout_top
  import pwl_pkg::*;
#(
  parameter int PW_BYTES = 8,
  parameter int MAX_TRIES = 8,
  parameter logic [PW_BYTES*8-1:0] INIT_READ_PW  = 64'h1111_2222_3333_4444,
  parameter logic [PW_BYTES*8-1:0] INIT_WRITE_PW = 64'h5555_6666_7777_8888,
  parameter logic [PW_BYTES*8-1:0] INIT_RESET_PW = 64'h9999_AAAA_BBBB_CCCC
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid_i,
  input  logic [1:0]            req_op_i,
  input  logic [1:0]            req_kind_i,
  input  logic [PW_BYTES*8-1:0] req_pw_i,
  output logic                  rsp_valid_o,
  output logic                  rsp_grant_o,
  output logic                  locked_o,
  output logic                  clr_array_o
);
  localparam int PW_BITS = PW_BYTES * 8;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  pwl_op_e   op;
  pwl_kind_e kind;
  assign op   = pwl_op_e'(req_op_i);
  assign kind = pwl_kind_e'(req_kind_i);

  logic [NUM_SLOTS*PW_BITS-1:0] pw_flat;
  logic kind_hit, reset_hit;
  logic fail, clear_cnt, unlock, zero_pw, overflow, locked;
  logic grant_d, clr_d;
  logic rsp_valid_q, rsp_grant_q, clr_q;

  pwl_pw_store #(
    .PW_BITS  (PW_BITS),
    .NUM_SLOTS(NUM_SLOTS),
    .INIT_PW  ({INIT_RESET_PW, INIT_WRITE_PW, INIT_READ_PW})
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .zero_en_i(zero_pw),
    .pw_flat_o(pw_flat)
  );

  pwl_compare #(.PW_BITS(PW_BITS)) u_cmp (
    .attempt_i  (req_pw_i),
    .pw_flat_i  (pw_flat),
    .kind_i     (kind),
    .kind_hit_o (kind_hit),
    .reset_hit_o(reset_hit)
  );

  pwl_retry_cnt #(.MAX_TRIES(MAX_TRIES)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .fail_i    (fail),
    .clear_i   (clear_cnt),
    .unlock_i  (unlock),
    .locked_o  (locked),
    .overflow_o(overflow)
  );

  always_comb begin
    grant_d   = 1'b0;
    fail      = 1'b0;
    clear_cnt = 1'b0;
    unlock    = 1'b0;
    zero_pw   = 1'b0;
    if (req_valid_i) begin
      case (op)
        OP_VERIFY: begin
          if (!locked && kind_hit) begin
            grant_d   = 1'b1;
            clear_cnt = 1'b1;
          end else begin
            fail = !locked;
          end
        end
        OP_RSTDEV: begin
          if (reset_hit) begin
            grant_d   = 1'b1;
            clear_cnt = 1'b1;
            unlock    = locked;
          end else begin
            fail = !locked;
          end
        end
        OP_RSTPW: begin
          if (reset_hit) begin
            grant_d   = 1'b1;
            clear_cnt = 1'b1;
            zero_pw   = 1'b1;
          end else begin
            fail = !locked;
          end
        end
        default: grant_d = 1'b0;
      endcase
    end
  end

  assign clr_d = overflow | zero_pw;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_valid_q <= 1'b0;
      rsp_grant_q <= 1'b0;
      clr_q       <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_grant_q <= grant_d;
      clr_q       <= clr_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_grant_o = rsp_grant_q;
  assign clr_array_o = clr_q;
  assign locked_o    = locked;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid_i |=> rsp_valid_o); // R2
  AST_LOCK_DENIES: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid_i && op == OP_VERIFY && locked_o) |=> (rsp_valid_o && !rsp_grant_o)); // R6
  AST_UNLOCK_SRC: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(locked_o) |-> $past(req_valid_i && op == OP_RSTDEV)); // R9
  AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_i_n)
    clr_array_o |-> (rsp_valid_o && ($rose(locked_o) || rsp_grant_o))); // R4
  AST_RSVD_DENY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid_i && op == OP_RSVD) |=> !rsp_grant_o); // R11
endmodule

// File: tb/sim_pwl_lockout_top.sv
module sim_pwl_lockout_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] RD  = 64'h1111_2222_3333_4444;
  localparam logic [63:0] WR  = 64'h5555_6666_7777_8888;
  localparam logic [63:0] RS  = 64'h9999_AAAA_BBBB_CCCC;
  localparam logic [63:0] BAD = 64'hDEAD_BEEF_0000_0001;
  localparam int NVEC = 20;

  // {op[1:0], kind[1:0], pw[63:0], grant, locked, clr}
  localparam logic [70:0] VEC [NVEC] = '{
    {2'd0, 2'd0, RD,  1'b1, 1'b0, 1'b0}, // R2 read ok
    {2'd0, 2'd1, WR,  1'b1, 1'b0, 1'b0}, // R2 write ok
    {2'd0, 2'd0, WR,  1'b0, 1'b0, 1'b0}, // R2 wrong kind
    {2'd0, 2'd1, BAD, 1'b0, 1'b0, 1'b0}, // R5
    {2'd1, 2'd0, BAD, 1'b0, 1'b0, 1'b0}, // R5 bad reset-device
    {2'd1, 2'd0, RS,  1'b1, 1'b0, 1'b0}, // R8
    {2'd0, 2'd0, BAD, 1'b0, 1'b0, 1'b0}, // R4 fail 1
    {2'd0, 2'd1, BAD, 1'b0, 1'b0, 1'b0}, // fail 2
    {2'd1, 2'd0, BAD, 1'b0, 1'b0, 1'b0}, // fail 3
    {2'd2, 2'd0, BAD, 1'b0, 1'b0, 1'b0}, // fail 4
    {2'd0, 2'd0, RS,  1'b0, 1'b0, 1'b0}, // fail 5
    {2'd0, 2'd1, RD,  1'b0, 1'b0, 1'b0}, // fail 6
    {2'd0, 2'd3, RD,  1'b0, 1'b0, 1'b0}, // fail 7
    {2'd1, 2'd0, WR,  1'b0, 1'b0, 1'b0}, // fail 8
    {2'd0, 2'd1, BAD, 1'b0, 1'b1, 1'b1}, // R4 ninth locks
    {2'd0, 2'd0, RD,  1'b0, 1'b1, 1'b0}, // R6
    {2'd3, 2'd0, RD,  1'b0, 1'b1, 1'b0}, // R11 while locked
    {2'd1, 2'd0, RS,  1'b1, 1'b0, 1'b0}, // R9
    {2'd0, 2'd0, RD,  1'b1, 1'b0, 1'b0}, // R7
    {2'd3, 2'd0, RD,  1'b0, 1'b0, 1'b0}  // R11
  };

  logic clk, rst_n, req_valid;
  logic [1:0] req_op, req_kind;
  logic [63:0] req_pw;
  logic rsp_valid, rsp_grant, locked, clr;
  int tests, fails;
  bit done;

  pwl_lockout_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_kind_i(req_kind), .req_pw_i(req_pw), .rsp_valid_o(rsp_valid),
    .rsp_grant_o(rsp_grant), .locked_o(locked), .clr_array_o(clr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {valid,grant,locked,clr} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [1:0] kind, input logic [63:0] pw);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_kind = kind; req_pw = pw;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_chk(input string req, input logic [1:0] op, input logic [1:0] kind,
                          input logic [63:0] pw, input logic g, input logic l, input logic c);
    send(op, kind, pw);
    chk(req, {rsp_valid, rsp_grant, locked, clr}, {1'b1, g, l, c});
  endtask

  initial begin
    tests = 0; fails = 0; done = 1'b0;
    req_valid = 1'b0; req_op = '0; req_kind = '0; req_pw = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {rsp_valid, rsp_grant, locked, clr}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", {rsp_valid, rsp_grant, locked, clr}, 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      send_chk($sformatf("vector %0d (R2/R4/R5/R6/R7/R8/R9/R11)", i),
               VEC[i][70:69], VEC[i][68:67], VEC[i][66:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end
    @(negedge clk);
    chk("R4 clear pulse gone when idle", {rsp_valid, rsp_grant, locked, clr}, 4'b0000);

    // R3: a grant mid-run restores the full allowance
    for (int i = 0; i < 5; i++) send(2'd0, 2'd0, BAD);
    send_chk("R3 grant after 5 fails", 2'd0, 2'd1, WR, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send(2'd0, 2'd0, BAD);
    chk("R3 eight fails after grant stay unlocked", {1'b0, 1'b0, locked, clr}, 4'b0000);
    send_chk("R3 reset via good password", 2'd0, 2'd2, RS, 1'b1, 1'b0, 1'b0);

    // R11: reserved ops do not count
    for (int i = 0; i < 8; i++) send(2'd0, 2'd1, BAD);
    send_chk("R11 reserved op denied", 2'd3, 2'd0, BAD, 1'b0, 1'b0, 1'b0);
    send_chk("R11 reserved op denied again", 2'd3, 2'd1, WR, 1'b0, 1'b0, 1'b0);
    send_chk("R11 next fail is the ninth", 2'd0, 2'd0, BAD, 1'b0, 1'b1, 1'b1);
    send_chk("R6 write denied while locked", 2'd0, 2'd1, WR, 1'b0, 1'b1, 1'b0);
    send_chk("R9 unlock", 2'd1, 2'd0, RS, 1'b1, 1'b0, 1'b0);
    send_chk("R7 write password kept", 2'd0, 2'd1, WR, 1'b1, 1'b0, 1'b0);

    // R10: reset-password
    send_chk("R10 bad reset-password denied", 2'd2, 2'd0, RD, 1'b0, 1'b0, 1'b0);
    send_chk("R10 reset-password pulse", 2'd2, 2'd0, RS, 1'b1, 1'b0, 1'b1);
    send_chk("R10 old read password denied", 2'd0, 2'd0, RD, 1'b0, 1'b0, 1'b0);
    send_chk("R10 zero read password", 2'd0, 2'd0, 64'h0, 1'b1, 1'b0, 1'b0);
    send_chk("R10 zero write password", 2'd0, 2'd1, 64'h0, 1'b1, 1'b0, 1'b0);
    send_chk("R10 zero reset password", 2'd1, 2'd0, 64'h0, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule